// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of an SDRAM interface. It moves the memory into and out of its two low-power conditions, self refresh and power down. A host raises a level request for one of them. The sequencer checks the entry preconditions and drives the chip-select, row-strobe, column-strobe, write-enable and clock-enable pins. It holds the pins quiet while the memory sleeps. On the way out it waits the exit delay before it raises `ready`, and `ready` tells the host that normal accesses may resume.

The two modes are not handled alike. Self refresh only needs every bank to be precharged, and its exit waits a full row cycle (`T_RC` clocks). Power down also needs the row-precharge time (`T_RP`) to have run since the last precharge. Its exit costs one clock. The memory does not refresh itself while powered down, so a down-counter is loaded with `T_REF - REF_MARGIN` when the block enters power down. If the host has not asked to leave by the time that counter runs out, the block wakes the memory itself. All timing values are elaboration-time parameters counted in clock cycles.

States:
- `ST_ACTIVE`: normal operation.
- `ST_SR_ENTER`: the one-cycle self-refresh command.
- `ST_SR`: sleeping in self refresh.
- `ST_SR_EXIT`: the row-cycle wait.
- `ST_PD_ENTER`: the one-cycle power-down entry.
- `ST_PD`: sleeping in power down.
- `ST_PD_EXIT`: the one-cycle wake.

Transitions:
- ACTIVE→SR_ENTER: `sr_req` is high and the banks are idle.
- ACTIVE→PD_ENTER: `pd_req` is high, `sr_req` is low, the banks are idle and the precharge time has elapsed.
- SR_ENTER→SR and PD_ENTER→PD: unconditional.
- SR→SR_EXIT: `exit_req` is high.
- SR_EXIT→ACTIVE: the row-cycle count is done.
- PD→PD_EXIT: `exit_req` is high or the refresh budget has expired.
- PD_EXIT→ACTIVE: unconditional.

Top module: `sdram_lp_seq`

## Requirements
- R1: During and right after reset the outputs show normal operation: `cke`=1, `ready`=1, and a NOP command (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1).
- R2: When `sr_req`=1 and `banks_idle`=1 are sampled in normal operation, the next cycle shows the self-refresh command for exactly one cycle: `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `cke`=0.
- R3: `sr_req` sampled with `banks_idle`=0 has no effect, and the outputs stay in normal operation.
- R4: In self refresh, `cke` stays 0 and the pins show deselect (all four command pins 1) until `exit_req` is sampled. `cke` is 1 in the next cycle, and `ready` rises exactly `T_RC` cycles after `cke` rises.
- R5: A power-down request is refused when `banks_idle`=0, or on the edge that samples `pre_issued`, or on any of the `T_RP` edges after that edge. An accepted request drives `cke`=0 with a NOP in the next cycle, and deselect follows from then on.
- R6: In power down, a sampled `exit_req` drives `cke`=1 (with deselect) in the next cycle, and `ready`=1 one cycle after that.
- R7: Without an exit request, `cke` stays low for exactly `T_REF - REF_MARGIN` cycles from power-down entry and then rises. It is never low longer than that.
- R8: When `sr_req` and `pd_req` are both high, self refresh is chosen.
- R9: `sr_req` and `pd_req` are ignored in any low-power or exit state, and `exit_req` is ignored in normal operation.
- R10: `ready` is 0 in every state except normal operation, and `ready`=1 implies `cke`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request to enter self refresh |
| pd_req | input | 1 | Level request to enter power down |
| exit_req | input | 1 | Request to leave the current low-power state |
| banks_idle | input | 1 | High when every bank is precharged |
| pre_issued | input | 1 | Pulse marking a precharge command just issued |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| ready | output | 1 | Normal accesses may be issued |

## Verification
Several properties are checked on every cycle:
- Each entry into a low-power state is checked against its own precondition from the cycle before.
- `ready` never appears without `cke`.
- After the first cycle of `cke` low, the pins always show deselect.
- The power-down stay never reaches the refresh budget.
- The timing counters never wrap below zero.

The exact cycle counts can only be shown by the bench's scenarios: the `T_RC` exit wait, the one-cycle power-down wake, the `T_RP` refusal window and the forced wake at `T_REF - REF_MARGIN`. The same holds for the priority of self refresh and for the requests that must be ignored.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_SR_ENTER = 3'd1,
        ST_SR       = 3'd2,
        ST_SR_EXIT  = 3'd3,
        ST_PD_ENTER = 3'd4,
        ST_PD       = 3'd5,
        ST_PD_EXIT  = 3'd6
    } lp_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] cmd_pins_t;

    localparam cmd_pins_t CMD_NOP      = 4'b0111;
    localparam cmd_pins_t CMD_DESELECT = 4'b1111;
    localparam cmd_pins_t CMD_SELF_REF = 4'b0001;

endpackage

// File: rtl/lp_down_counter.sv
module lp_down_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             en,
    output logic             zero
);

    logic [WIDTH-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (en && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);

    // A drained counter stays drained until it is reloaded.
    AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero); // R7

endmodule

// File: rtl/lp_pin_encoder.sv
module lp_pin_encoder
    import sdram_lp_pkg::*;
(
    input  lp_state_t state,
    output cmd_pins_t cmd,
    output logic      cke,
    output logic      ready
);

    always_comb begin
        cmd   = CMD_DESELECT;
        cke   = 1'b0;
        ready = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                cmd   = CMD_NOP;
                cke   = 1'b1;
                ready = 1'b1;
            end
            ST_SR_ENTER: begin
                cmd = CMD_SELF_REF;
                cke = 1'b0;
            end
            ST_SR, ST_PD: begin
                cmd = CMD_DESELECT;
                cke = 1'b0;
            end
            ST_PD_ENTER: begin
                cmd = CMD_NOP;
                cke = 1'b0;
            end
            ST_SR_EXIT, ST_PD_EXIT: begin
                cmd = CMD_DESELECT;
                cke = 1'b1;
            end
            default: begin
                cmd   = CMD_DESELECT;
                cke   = 1'b1;
                ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdram_lp_pkg::*;
#(
    parameter int T_RC       = 8,
    parameter int T_RP       = 3,
    parameter int T_REF      = 100000,
    parameter int REF_MARGIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic pd_req,
    input  logic exit_req,
    input  logic banks_idle,
    input  logic pre_issued,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic ready
);

    localparam int PD_LIMIT = T_REF - REF_MARGIN;
    localparam int RCW      = $clog2(T_RC + 1);
    localparam int RPW      = $clog2(T_RP + 1);
    localparam int RFW      = $clog2(T_REF + 1);

    localparam logic [RCW-1:0] RC_LOAD  = RCW'(T_RC - 1);
    localparam logic [RPW-1:0] RP_LOAD  = RPW'(T_RP);
    localparam logic [RFW-1:0] REF_LOAD = RFW'(PD_LIMIT - 1);

    lp_state_t state_q, state_nx;

    logic      trp_zero, trp_ok;
    logic      rc_zero, rc_load, rc_en;
    logic      ref_zero, ref_load, ref_en;
    cmd_pins_t cmd;

    // ---------------- timing counters ----------------
    lp_down_counter #(.WIDTH(RPW)) u_trp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pre_issued),
        .load_val (RP_LOAD),
        .en       (1'b1),
        .zero     (trp_zero)
    );

    assign trp_ok = trp_zero && !pre_issued;

    assign rc_load = (state_q == ST_SR) && exit_req;
    assign rc_en   = (state_q == ST_SR_EXIT);

    lp_down_counter #(.WIDTH(RCW)) u_rc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rc_load),
        .load_val (RC_LOAD),
        .en       (rc_en),
        .zero     (rc_zero)
    );

    assign ref_load = (state_q == ST_ACTIVE) && (state_nx == ST_PD_ENTER);
    assign ref_en   = (state_q == ST_PD_ENTER) || (state_q == ST_PD);

    lp_down_counter #(.WIDTH(RFW)) u_ref_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ref_load),
        .load_val (REF_LOAD),
        .en       (ref_en),
        .zero     (ref_zero)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sr_req) begin
                    if (banks_idle) state_nx = ST_SR_ENTER;
                end else if (pd_req && banks_idle && trp_ok) begin
                    state_nx = ST_PD_ENTER;
                end
            end
            ST_SR_ENTER: state_nx = ST_SR;
            ST_SR:       if (exit_req) state_nx = ST_SR_EXIT;
            ST_SR_EXIT:  if (rc_zero) state_nx = ST_ACTIVE;
            ST_PD_ENTER: state_nx = ST_PD;
            ST_PD:       if (exit_req || ref_zero) state_nx = ST_PD_EXIT;
            ST_PD_EXIT:  state_nx = ST_ACTIVE;
            default:     state_nx = ST_ACTIVE;
        endcase
    end

    // ---------------- outputs ----------------
    lp_pin_encoder u_enc (
        .state (state_q),
        .cmd   (cmd),
        .cke   (cke),
        .ready (ready)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // ---------------- checks ----------------
    logic [RFW-1:0] pd_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_low_cnt <= '0;
        end else if ((state_q == ST_PD_ENTER) || (state_q == ST_PD)) begin
            pd_low_cnt <= pd_low_cnt + 1'b1;
        end else begin
            pd_low_cnt <= '0;
        end
    end

    AST_SR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_ENTER) |-> $past(banks_idle)); // R3

    AST_PD_NEEDS_TRP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PD_ENTER) |-> ($past(banks_idle) && $past(trp_zero) && !$past(pre_issued))); // R5

    AST_PD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PD) |-> (pd_low_cnt < RFW'(PD_LIMIT))); // R7

    AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke); // R10

    AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$past(cke)) |-> cs_n); // R4

endmodule

// File: tb/sdram_lp_seq_bench.sv
module sdram_lp_seq_bench;

    localparam int T_RC       = 4;
    localparam int T_RP       = 3;
    localparam int T_REF      = 40;
    localparam int REF_MARGIN = 8;
    localparam int LIM        = T_REF - REF_MARGIN;

    // expected bundle order: {cke, cs_n, ras_n, cas_n, we_n, ready}
    localparam logic [5:0] X_ACT  = 6'b101111;
    localparam logic [5:0] X_SRE  = 6'b000010;
    localparam logic [5:0] X_DES  = 6'b011110;
    localparam logic [5:0] X_PDE  = 6'b001110;
    localparam logic [5:0] X_WAKE = 6'b111110;

    typedef struct {
        logic [5:0] v;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0, pd_req = 1'b0, exit_req = 1'b0;
    logic banks_idle = 1'b0, pre_issued = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, ready;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    sdram_lp_seq #(
        .T_RC(T_RC), .T_RP(T_RP), .T_REF(T_REF), .REF_MARGIN(REF_MARGIN)
    ) u_sdram_lp_seq (
        .clk(clk), .rst_n(rst_n),
        .sr_req(sr_req), .pd_req(pd_req), .exit_req(exit_req),
        .banks_idle(banks_idle), .pre_issued(pre_issued),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ready(ready)
    );

    // monitor: compares the outputs after each edge against the queued expectation
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t it;
            logic [5:0] act;
            it  = exp_q.pop_front();
            act = {cke, cs_n, ras_n, cas_n, we_n, ready};
            n_checks++;
            if (act !== it.v) begin
                n_fail++;
                $display("FAIL %s: pins {cke,cs_n,ras_n,cas_n,we_n,ready} actual %b expected %b",
                         it.tag, act, it.v);
            end
        end
    end

    // driver: applies inputs for one edge and queues the outputs expected after it
    task automatic step(input logic sr, input logic pd, input logic ex,
                        input logic idle, input logic pre,
                        input logic [5:0] e, input string tag);
        @(negedge clk);
        sr_req     = sr;
        pd_req     = pd;
        exit_req   = ex;
        banks_idle = idle;
        pre_issued = pre;
        exp_q.push_back('{v: e, tag: tag});
    endtask

    initial begin
        // R1 reset state
        step(0, 0, 0, 0, 0, X_ACT, "R1 in reset");
        step(0, 0, 0, 0, 0, X_ACT, "R1 in reset");
        rst_n = 1'b1;
        step(0, 0, 0, 1, 0, X_ACT, "R1 after reset");

        // R3 self refresh refused while banks busy
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, X_ACT, "R3 busy banks");

        // R9 exit request ignored in normal operation
        step(0, 0, 1, 1, 0, X_ACT, "R9 exit in active");

        // R2 self refresh entry, one command cycle
        step(1, 0, 0, 1, 0, X_SRE, "R2 sr command");
        step(0, 0, 0, 1, 0, X_DES, "R2 single cycle");
        // R9 requests ignored while asleep
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, X_DES, "R9 req in sr");
        step(0, 0, 0, 1, 0, X_DES, "R4 sr hold");

        // R4 exit with row-cycle wait
        step(0, 0, 1, 1, 0, X_WAKE, "R4 cke rise");
        for (int i = 1; i < T_RC; i++) step(1, 1, 0, 1, 0, X_WAKE, "R4 R10 trc wait");
        step(0, 0, 0, 1, 0, X_ACT, "R4 ready after trc");

        // R5 power down refused with busy banks
        step(0, 1, 0, 0, 0, X_ACT, "R5 busy banks");
        // R5 refused on the precharge edge and the T_RP edges after it
        step(0, 1, 0, 1, 1, X_ACT, "R5 precharge edge");
        for (int i = 0; i < T_RP; i++) step(0, 1, 0, 1, 0, X_ACT, "R5 trp window");
        step(0, 1, 0, 1, 0, X_PDE, "R5 pd entry");
        step(0, 0, 0, 1, 0, X_DES, "R5 pd deselect");
        step(1, 1, 0, 1, 0, X_DES, "R9 req in pd");
        step(0, 0, 0, 1, 0, X_DES, "R5 pd hold");

        // R6 one-cycle wake from power down
        step(0, 0, 1, 1, 0, X_WAKE, "R6 cke rise");
        step(0, 0, 0, 1, 0, X_ACT, "R6 ready");

        // R7 forced wake after the refresh budget
        step(0, 1, 0, 1, 0, X_PDE, "R7 pd entry");
        for (int i = 1; i < LIM; i++)
            step(i == 5, i == 6, 0, 1, 0, X_DES, "R7 R9 budget hold");
        step(0, 0, 0, 1, 0, X_WAKE, "R7 forced wake");
        step(0, 0, 0, 1, 0, X_ACT, "R7 back to active");

        // R8 self refresh wins over power down
        step(1, 1, 0, 1, 0, X_SRE, "R8 priority");
        step(0, 0, 0, 1, 0, X_DES, "R8 in sr");
        step(0, 0, 1, 1, 0, X_WAKE, "R8 exit");
        for (int i = 1; i < T_RC; i++) step(0, 0, 0, 1, 0, X_WAKE, "R10 trc wait");
        step(0, 0, 0, 1, 0, X_ACT, "R10 ready");

        @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule